// File: doc/BRIEF.md
# SENT Frame Transmitter

This block drives one single-edge nibble (SENT) output line. Every frame opens with a calibration (sync) period. The status nibble follows, then one to six data nibbles. An optional CRC nibble and an optional pause period close the frame. Every period begins with a fixed four-tick pulse at the active level. The time between the starts of two pulses carries the value being sent. A tick is built from the module clock in two steps: a fixed divide-by-1 or divide-by-4, then a programmable count of prescaled clocks.

The surrounding logic holds the configuration on plain input pins and loads the nibble contents. In continuous mode, frames follow one another with no gap for as long as the block is enabled. In triggered mode, a one-cycle request sets a pending flag, which the block reports on an output. The block then sends exactly one frame and clears the flag itself when that frame ends. At the start of each frame the block captures the nibble contents, the nibble count and the CRC and pause settings. Software can therefore load the next values while the current frame is on the line.

The state machine has six states:
- `ST_IDLE`: the line rests at the idle level.
- `ST_SYNC`: the calibration period is on the line.
- `ST_STATUS`: the status nibble is on the line.
- `ST_DATA`: the data nibbles are on the line, one after another.
- `ST_CRC`: the CRC nibble is on the line.
- `ST_PAUSE`: the pause period is on the line.

The transitions are:
- IDLE→SYNC when the block is enabled and either continuous mode is selected or a trigger is pending.
- SYNC→STATUS and STATUS→DATA at the end of each period.
- DATA→DATA after each data nibble except the last.
- After the last data nibble, DATA goes to CRC if CRC is on, else to PAUSE if the pause is on, else the frame ends.
- CRC→PAUSE, or the frame ends.
- PAUSE: the frame ends.
- At the end of a frame the block goes to SYNC in continuous mode and to IDLE in triggered mode.
- Any state goes to IDLE when `enable` falls.

Top module: `sent_frame_tx`

## Requirements
- R1: After reset, `tx_out` is 1, because the idle level for `idle_low`=0 is high. `trig_pending` is 0 after reset.
- R2: Outside a pulse, `tx_out` equals `!idle_low`. During a pulse, `tx_out` equals `idle_low`.
- R3: One tick lasts `tick_len` prescaled clocks. A prescaled clock is 1 module clock when `div4`=0 and 4 module clocks when `div4`=1.
- R4: Each frame begins with a sync period of 56 ticks. Every period (sync, nibble and pause) begins with an active pulse of exactly 4 ticks. The remainder of the period is at the idle level.
- R5: A nibble of value v occupies 12+v ticks. The order on the line is: status nibble, then data nibble k=0,1,… taken from `data_nibs[4k+3:4k]`.
- R6: The number of data nibbles is given by `nib_count`. Codes 1 to 6 send that many nibbles. Code 0 is clamped to 1 nibble and code 7 to 6 nibbles.
- R7: With `crc_on`=1, a CRC nibble follows the data nibbles. It is computed as follows:
  - Start with c=0101.
  - For each data nibble d, set c = M(c) xor d, where M multiplies by x^4 modulo x^4+x^3+x^2+1.
  - The value sent is M(c).
  - The status nibble is not included.
  
  With `crc_on`=0, no CRC nibble is sent.
- R8: With `pause_on`=1, the frame ends with a pause period of `pause_len` ticks, which starts with the usual 4-tick pulse. With `pause_on`=0, there is no pause period.
- R9: With `trig_mode`=0 and `enable`=1, the next sync pulse starts on the clock edge that ends the previous frame.
- R10: With `trig_mode`=1, a `trig_set` pulse sets `trig_pending` at the next edge, but only while `enable`=1 and `trig_mode`=1; at any other time `trig_set` is ignored. Exactly one frame is then sent. `trig_pending` falls on the edge that ends that frame, including the pause if there is one.
- R11: When `enable` is 0, the block returns to idle at the next edge. This aborts any frame in progress and clears `trig_pending`.
- R12: The nibble values, the count, the CRC setting and the pause setting are captured when a frame starts. Changes made during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| trig_mode | input | 1 | 0: continuous frames, 1: one frame per trigger |
| idle_low | input | 1 | 0: line idles high, 1: line idles low |
| crc_on | input | 1 | Append CRC nibble |
| pause_on | input | 1 | Append pause period |
| div4 | input | 1 | Prescale the clock by 4 instead of 1 |
| nib_count | input | 3 | Data nibble count code |
| tick_len | input | TICK_W | Prescaled clocks per tick |
| pause_len | input | PAUSE_W | Pause period length in ticks |
| status_nib | input | 4 | Status nibble value |
| data_nibs | input | 24 | Data nibbles, nibble k in bits 4k+3:4k |
| trig_set | input | 1 | One-cycle request for a single frame |
| tx_out | output | 1 | SENT output line |
| trig_pending | output | 1 | Pending single-frame request |

## Verification
The assertions assume the following about the inputs:
- `tick_len` is at least 1.
- `pause_len` is at least 5, so that the pulse fits inside the pause.
- `tick_len`, `div4` and `idle_low` are not changed while a frame is running.

The stimulus respects these limits by changing the configuration only while the block is idle or disabled. Each scenario then waits two clocks before arming the line monitor. The one deliberate change during a frame affects only the captured nibble inputs, and it tests R12.

// File: rtl/sent_tx_pkg.sv
package sent_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_STATUS,
        ST_DATA,
        ST_CRC,
        ST_PAUSE
    } tx_state_e;

    localparam int          SYNC_TICKS  = 56;
    localparam int          PULSE_TICKS = 4;
    localparam int          NIB_BASE    = 12;
    localparam int          NIB_MAX     = 6;
    localparam int          DATA_W      = 4 * NIB_MAX;
    localparam logic [3:0]  CRC_SEED    = 4'b0101;
    localparam logic [3:0]  CRC_RED     = 4'b1101;

    // multiply a 4-bit residue by x^4 modulo x^4+x^3+x^2+1
    function automatic logic [3:0] crc_mulx4(input logic [3:0] c);
        logic [3:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            r = {r[2:0], 1'b0} ^ (r[3] ? CRC_RED : 4'b0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/sent_tick_gen.sv
module sent_tick_gen #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              div4,
    input  logic [TICK_W-1:0] tick_len,
    output logic              tick
);
    logic [1:0]        pre_q;
    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W:0]   cnt_inc;
    logic              pre_strobe;
    logic              cnt_last;

    assign pre_strobe = !div4 || (pre_q == 2'd3);
    assign cnt_inc    = {1'b0, cnt_q} + {{TICK_W{1'b0}}, 1'b1};
    assign cnt_last   = cnt_inc >= {1'b0, tick_len};
    assign tick       = run && pre_strobe && cnt_last;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_strobe ? 2'd0 : pre_q + 2'd1;
            if (pre_strobe) begin
                cnt_q <= cnt_last ? '0 : cnt_inc[TICK_W-1:0];
            end
        end
    end
endmodule

// File: rtl/sent_crc_acc.sv
module sent_crc_acc
    import sent_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step_en,
    input  logic [3:0] nib,
    output logic [3:0] crc_out
);
    logic [3:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= CRC_SEED;
        end else if (step_en) begin
            acc_q <= crc_mulx4(acc_q) ^ nib;
        end
    end

    // final augmentation with a zero nibble
    assign crc_out = crc_mulx4(acc_q);
endmodule

// File: rtl/sent_frame_tx.sv
module sent_frame_tx
    import sent_tx_pkg::*;
#(
    parameter int TICK_W  = 8,
    parameter int PAUSE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               trig_mode,
    input  logic               idle_low,
    input  logic               crc_on,
    input  logic               pause_on,
    input  logic               div4,
    input  logic [2:0]         nib_count,
    input  logic [TICK_W-1:0]  tick_len,
    input  logic [PAUSE_W-1:0] pause_len,
    input  logic [3:0]         status_nib,
    input  logic [23:0]        data_nibs,
    input  logic               trig_set,
    output logic               tx_out,
    output logic               trig_pending
);
    localparam int SEG_W = (PAUSE_W > 6) ? PAUSE_W : 6;

    tx_state_e          state_q, state_d;
    logic [SEG_W-1:0]   seg_cnt_q, seg_len;
    logic [2:0]         nib_idx_q;
    logic [3:0]         snap_status;
    logic [DATA_W-1:0]  snap_data;
    logic [2:0]         snap_cnt;
    logic               snap_crc, snap_pause;
    logic [PAUSE_W-1:0] snap_pause_len;
    logic               trig_pend_q;
    logic               tick, seg_last, last_nib;
    logic               start_frame, frame_end;
    logic [3:0]         cur_nib, crc_nib;
    logic [2:0]         cnt_clamped;
    logic               pulse_on;

    sent_tick_gen #(.TICK_W(TICK_W)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .div4     (div4),
        .tick_len (tick_len),
        .tick     (tick)
    );

    sent_crc_acc crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_frame),
        .step_en ((state_q == ST_DATA) && seg_last),
        .nib     (cur_nib),
        .crc_out (crc_nib)
    );

    assign cur_nib     = snap_data[{nib_idx_q, 2'b00} +: 4];
    assign last_nib    = (nib_idx_q == snap_cnt - 3'd1);
    assign cnt_clamped = (nib_count == 3'd0) ? 3'd1 :
                         (nib_count == 3'd7) ? 3'd6 : nib_count;

    always_comb begin
        unique case (state_q)
            ST_SYNC:   seg_len = SEG_W'(SYNC_TICKS);
            ST_STATUS: seg_len = SEG_W'(NIB_BASE) + SEG_W'(snap_status);
            ST_DATA:   seg_len = SEG_W'(NIB_BASE) + SEG_W'(cur_nib);
            ST_CRC:    seg_len = SEG_W'(NIB_BASE) + SEG_W'(crc_nib);
            ST_PAUSE:  seg_len = SEG_W'(snap_pause_len);
            default:   seg_len = SEG_W'(SYNC_TICKS);
        endcase
    end

    assign seg_last = tick && (seg_cnt_q == seg_len - SEG_W'(1));

    // next-state logic
    always_comb begin
        state_d     = state_q;
        start_frame = 1'b0;
        frame_end   = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!trig_mode || trig_pend_q) begin
                        state_d     = ST_SYNC;
                        start_frame = 1'b1;
                    end
                end
                ST_SYNC:   if (seg_last) state_d = ST_STATUS;
                ST_STATUS: if (seg_last) state_d = ST_DATA;
                ST_DATA: begin
                    if (seg_last && last_nib) begin
                        if (snap_crc)        state_d = ST_CRC;
                        else if (snap_pause) state_d = ST_PAUSE;
                        else                 frame_end = 1'b1;
                    end
                end
                ST_CRC: begin
                    if (seg_last) begin
                        if (snap_pause) state_d = ST_PAUSE;
                        else            frame_end = 1'b1;
                    end
                end
                ST_PAUSE:  if (seg_last) frame_end = 1'b1;
                default:   state_d = ST_IDLE;
            endcase
            if (frame_end) begin
                if (!trig_mode) begin
                    state_d     = ST_SYNC;
                    start_frame = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters, frame capture, trigger flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_cnt_q      <= '0;
            nib_idx_q      <= '0;
            snap_status    <= '0;
            snap_data      <= '0;
            snap_cnt       <= 3'd1;
            snap_crc       <= 1'b0;
            snap_pause     <= 1'b0;
            snap_pause_len <= '0;
            trig_pend_q    <= 1'b0;
        end else begin
            trig_pend_q <= enable && ((trig_set && trig_mode) ||
                                      (trig_pend_q && !frame_end));
            if (state_d == ST_IDLE) begin
                seg_cnt_q <= '0;
                nib_idx_q <= '0;
            end else if (start_frame || seg_last) begin
                seg_cnt_q <= '0;
                if (start_frame)                nib_idx_q <= '0;
                else if (state_q == ST_DATA)    nib_idx_q <= nib_idx_q + 3'd1;
            end else if (tick) begin
                seg_cnt_q <= seg_cnt_q + SEG_W'(1);
            end
            if (start_frame) begin
                snap_status    <= status_nib;
                snap_data      <= data_nibs;
                snap_cnt       <= cnt_clamped;
                snap_crc       <= crc_on;
                snap_pause     <= pause_on;
                snap_pause_len <= pause_len;
            end
        end
    end

    // outputs
    always_comb begin
        pulse_on     = (state_q != ST_IDLE) && (seg_cnt_q < SEG_W'(PULSE_TICKS));
        tx_out       = pulse_on ? idle_low : !idle_low;
        trig_pending = trig_pend_q;
    end

endmodule

// File: rtl/sent_frame_tx_chk.sv
module sent_frame_tx_chk
    import sent_tx_pkg::*;
#(
    parameter int SEG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             trig_mode,
    input logic             trig_set,
    input logic             idle_low,
    input logic             tx_out,
    input logic             trig_pending,
    input tx_state_e        state_q,
    input logic             frame_end,
    input logic [2:0]       nib_idx_q,
    input logic [2:0]       snap_cnt,
    input logic [SEG_W-1:0] seg_cnt_q,
    input logic [SEG_W-1:0] seg_len
);
    // R11: disabled block rests at the idle level one edge later
    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tx_out == !idle_low));

    // R11: disabling drops any pending trigger
    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !trig_pending);

    // R10: pending flag only rises from an accepted request
    a_r10_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_pending) |-> $past(trig_set && trig_mode && enable));

    // R10: pending flag only falls at frame end or on disable
    a_r10_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_pending) |-> $past(frame_end || !enable));

    // R4: the position within a period never passes its length
    a_r4_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (seg_cnt_q < seg_len));

    // R6: data index stays below the captured count
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (nib_idx_q < snap_cnt));

    // R9: continuous mode restarts with a sync pulse at once
    a_r9_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !trig_mode) |=>
            (state_q == ST_SYNC) && (seg_cnt_q == '0) && (tx_out == idle_low));
endmodule

bind sent_frame_tx sent_frame_tx_chk #(.SEG_W(SEG_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .trig_mode    (trig_mode),
    .trig_set     (trig_set),
    .idle_low     (idle_low),
    .tx_out       (tx_out),
    .trig_pending (trig_pending),
    .state_q      (state_q),
    .frame_end    (frame_end),
    .nib_idx_q    (nib_idx_q),
    .snap_cnt     (snap_cnt),
    .seg_cnt_q    (seg_cnt_q),
    .seg_len      (seg_len)
);

// File: tb/sent_frame_tx_tb.sv
module sent_frame_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        trig_mode = 1'b0;
    logic        idle_low = 1'b0;
    logic        crc_on = 1'b0;
    logic        pause_on = 1'b0;
    logic        div4 = 1'b0;
    logic [2:0]  nib_count = 3'd6;
    logic [7:0]  tick_len = 8'd1;
    logic [11:0] pause_len = 12'd12;
    logic [3:0]  status_nib = 4'd0;
    logic [23:0] data_nibs = 24'd0;
    logic        trig_set = 1'b0;
    logic        tx_out;
    logic        trig_pending;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int rise_t[512];
    int fall_t[512];
    int n_rise = 0;
    int n_fall = 0;
    int n_pf   = 0;
    int pf_t   = 0;
    logic prev_tx = 1'b1;
    logic prev_pend = 1'b0;

    always #10 clk = ~clk;

    sent_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_mode(trig_mode),
        .idle_low(idle_low), .crc_on(crc_on), .pause_on(pause_on),
        .div4(div4), .nib_count(nib_count), .tick_len(tick_len),
        .pause_len(pause_len), .status_nib(status_nib),
        .data_nibs(data_nibs), .trig_set(trig_set),
        .tx_out(tx_out), .trig_pending(trig_pending)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // line monitor: pulse start and end times, pending fall times
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_out !== prev_tx) begin
                if (tx_out == idle_low) begin
                    if (n_rise < 512) rise_t[n_rise] = cyc;
                    n_rise = n_rise + 1;
                end else begin
                    if (n_fall < 512) fall_t[n_fall] = cyc;
                    n_fall = n_fall + 1;
                end
            end
            if (prev_pend && !trig_pending) begin
                pf_t = cyc;
                n_pf = n_pf + 1;
            end
        end
        prev_tx   = tx_out;
        prev_pend = trig_pending;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_crc(input logic [23:0] d, input int n);
        logic [3:0] r;
        logic b, fb;
        r = 4'b0101;
        for (int k = 0; k <= n; k++) begin
            for (int j = 3; j >= 0; j--) begin
                b  = (k < n) ? d[4*k + j] : 1'b0;
                fb = r[3];
                r  = {r[2:0], b} ^ (fb ? 4'b1101 : 4'b0000);
            end
        end
        return r;
    endfunction

    task automatic t_reset();
        check(tx_out == 1'b1, "R1 reset line level", int'(tx_out), 1);
        check(trig_pending == 1'b0, "R1 reset pending", int'(trig_pending), 0);
    endtask

    task automatic run_trig(input bit pol, input bit d4, input int tl, input int code,
                            input bit crc, input bit pse, input int plen,
                            input logic [3:0] st, input logic [23:0] dat, input bit mid);
        int n, p, k_tot, br, bf, bp, w, e;
        int exp_t[10];
        string tag[10];
        @(negedge clk);
        enable = 1'b1; trig_mode = 1'b1; idle_low = pol; div4 = d4;
        tick_len = 8'(tl); nib_count = 3'(code); crc_on = crc; pause_on = pse;
        pause_len = 12'(plen); status_nib = st; data_nibs = dat;
        repeat (2) @(negedge clk);
        br = n_rise; bf = n_fall; bp = n_pf;
        trig_set = 1'b1;
        @(negedge clk);
        trig_set = 1'b0;
        check(trig_pending == 1'b1, "R10 request sets pending", int'(trig_pending), 1);
        if (mid) begin
            repeat (20) @(negedge clk);
            status_nib = ~st; data_nibs = ~dat; crc_on = ~crc; pause_on = ~pse;
        end
        w = 0;
        while (n_pf == bp && w < 20000) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        n = (code == 0) ? 1 : (code == 7) ? 6 : code;
        p = tl * (d4 ? 4 : 1);
        exp_t[0] = 56;        tag[0] = "R3 R4 sync period";
        exp_t[1] = 12 + st;   tag[1] = "R5 status period";
        k_tot = 2;
        for (int k = 0; k < n; k++) begin
            exp_t[k_tot] = 12 + int'(dat[4*k +: 4]);
            tag[k_tot] = mid ? "R12 R5 R6 data period" : "R5 R6 data period";
            k_tot++;
        end
        if (crc) begin
            exp_t[k_tot] = 12 + int'(ref_crc(dat, n)); tag[k_tot] = "R7 crc period"; k_tot++;
        end
        if (pse) begin
            exp_t[k_tot] = plen; tag[k_tot] = "R8 pause period"; k_tot++;
        end
        check(n_rise - br == k_tot, "R6 R7 R8 pulse count", n_rise - br, k_tot);
        if (n_rise - br == k_tot) begin
            for (int k = 0; k < k_tot; k++) begin
                e = (k < k_tot - 1) ? rise_t[br + k + 1] : pf_t;
                check(e - rise_t[br + k] == exp_t[k] * p, tag[k],
                      e - rise_t[br + k], exp_t[k] * p);
                check(fall_t[bf + k] - rise_t[br + k] == 4 * p, "R4 pulse width",
                      fall_t[bf + k] - rise_t[br + k], 4 * p);
            end
        end
        repeat (40) @(negedge clk);
        check(n_rise - br == k_tot, "R10 single frame per request", n_rise - br, k_tot);
        check(tx_out == !pol, "R2 idle level after frame", int'(tx_out), int'(!pol));
        check(trig_pending == 1'b0, "R10 pending cleared", int'(trig_pending), 0);
        data_nibs = dat; status_nib = st; crc_on = crc; pause_on = pse;
    endtask

    task automatic t_ignored();
        int br;
        @(negedge clk);
        enable = 1'b0; trig_mode = 1'b1; idle_low = 1'b0;
        repeat (2) @(negedge clk);
        br = n_rise;
        trig_set = 1'b1;
        @(negedge clk);
        trig_set = 1'b0;
        check(trig_pending == 1'b0, "R10 request ignored while disabled", int'(trig_pending), 0);
        repeat (20) @(negedge clk);
        check(n_rise == br, "R10 no frame while disabled", n_rise - br, 0);
        check(tx_out == 1'b1, "R2 idle high while disabled", int'(tx_out), 1);
    endtask

    task automatic t_continuous();
        int br, bf, w, k_tot, t_tot, n;
        @(negedge clk);
        enable = 1'b0; trig_mode = 1'b0; idle_low = 1'b1; div4 = 1'b0;
        tick_len = 8'd1; nib_count = 3'd2; crc_on = 1'b1; pause_on = 1'b1;
        pause_len = 12'd20; status_nib = 4'h3; data_nibs = 24'h0000_9C;
        repeat (2) @(negedge clk);
        check(tx_out == 1'b0, "R2 idle low with polarity set", int'(tx_out), 0);
        br = n_rise; bf = n_fall;
        enable = 1'b1;
        n = 2;
        k_tot = 2 + n + 2;
        t_tot = 56 + (12 + 3) + (12 + 12) + (12 + 9) + (12 + int'(ref_crc(24'h9C, 2))) + 20;
        trig_set = 1'b1;
        @(negedge clk);
        trig_set = 1'b0;
        check(trig_pending == 1'b0, "R10 request ignored in continuous mode",
              int'(trig_pending), 0);
        w = 0;
        while (n_rise - br < 2 * k_tot + 1 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(n_rise - br >= 2 * k_tot + 1, "R9 frames keep coming", n_rise - br, 2 * k_tot + 1);
        check(rise_t[br + k_tot] - rise_t[br] == t_tot, "R9 back-to-back frame 1",
              rise_t[br + k_tot] - rise_t[br], t_tot);
        check(rise_t[br + 2 * k_tot] - rise_t[br + k_tot] == t_tot, "R9 back-to-back frame 2",
              rise_t[br + 2 * k_tot] - rise_t[br + k_tot], t_tot);
        w = 0;
        while (tx_out != 1'b1 && w < 1000) begin
            @(negedge clk);
            w++;
        end
        check(tx_out == 1'b1, "R2 active level opposite idle", int'(tx_out), 1);
        enable = 1'b0;
        @(negedge clk);
        check(tx_out == 1'b0, "R11 abort returns to idle", int'(tx_out), 0);
        br = n_rise;
        repeat (100) @(negedge clk);
        check(n_rise == br, "R11 no pulses after disable", n_rise - br, 0);
    endtask

    task automatic t_disable_pending();
        @(negedge clk);
        enable = 1'b1; trig_mode = 1'b1; idle_low = 1'b0; tick_len = 8'd2;
        nib_count = 3'd6; crc_on = 1'b0; pause_on = 1'b0;
        repeat (2) @(negedge clk);
        trig_set = 1'b1;
        @(negedge clk);
        trig_set = 1'b0;
        repeat (100) @(negedge clk);
        check(trig_pending == 1'b1, "R10 pending held during frame", int'(trig_pending), 1);
        enable = 1'b0;
        @(negedge clk);
        check(trig_pending == 1'b0, "R11 disable clears pending", int'(trig_pending), 0);
        check(tx_out == 1'b1, "R11 disable idles line", int'(tx_out), 1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 150000);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_trig(1'b0, 1'b0, 3, 6, 1'b1, 1'b0, 12, 4'hA, 24'h3C9F05, 1'b0);
        run_trig(1'b1, 1'b1, 2, 3, 1'b1, 1'b1, 30, 4'h0, 24'h000E7F, 1'b0);
        run_trig(1'b0, 1'b0, 1, 0, 1'b0, 1'b0, 12, 4'hF, 24'hABCDE7, 1'b0);
        run_trig(1'b0, 1'b0, 2, 7, 1'b0, 1'b1, 12, 4'h5, 24'h123456, 1'b0);
        run_trig(1'b0, 1'b0, 2, 4, 1'b1, 1'b1, 15, 4'h6, 24'h00F1A2, 1'b1);
        t_ignored();
        t_continuous();
        t_disable_pending();
        finish_run();
    end
endmodule